// File: doc/BRIEF.md
# Low-Address Guard and Prefix Remapper

This block sits on the path from a real address to an absolute address. It takes one access request at a time and does two things with it. It checks the access against a small write-protected window near the bottom of storage. It also swaps the two 8 KiB areas at address zero and at the per-CPU prefix, so that each CPU sees its own private low area. The results are registered and appear one clock after the request.

Protection depends on a control enable and on the translation state. When translation is off, the enable alone arms the guard. When translation is on, the guard is also gated by a private-space bit. That bit is taken from one of three space descriptors, and the address-space mode picks which one. The block flags every access whose page begins in the protected window, even when the access itself is allowed. A cache of translations can use this flag to avoid reusing the entry for later stores. One mode has no descriptor to select. An access in that mode with translation on is reported as an error.

Top module: `lap_prefix_xlate`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. All result outputs change only at the edge that captures a request and hold their value otherwise.
- R2: A byte address is low when it lies in 0..511 or 4096..4607. The page address is the input with bits [11:0] cleared. Addresses 512 and 4608 are not low.
- R3: The guard is armed when `lowprot_en` is 1 and either `dat_on` is 0 or the private bit of the selected descriptor is 0. `space_mode` selects as follows: 2'b00 selects `priv_primary`, 2'b10 selects `priv_secondary` and 2'b11 selects `priv_home`.
- R4: A store (`req_kind` 2'b01) to a low byte address with the guard armed sets `prot_fault`. `fault_code` is then the page address ORed with 0x400 and 0x80, and `abs_addr` is 0.
- R5: A read (`req_kind` 2'b00) or fetch (2'b10) never sets `prot_fault`, whatever its address.
- R6: `wr_inval_hint` is 1 when the page address is low and the guard is armed, whether or not the access faults. It is 0 otherwise.
- R7: With no fault, an address below 0x2000 maps to the address plus the prefix. Bits [12:0] of `prefix` are ignored.
- R8: With no fault, an address from the prefix up to (but not including) prefix+0x2000 maps to the address minus the prefix. Any other address passes through unchanged.
- R9: `space_mode` 2'b01 with `dat_on` 1 sets `mode_error` and forces `abs_addr`, `prot_fault`, `wr_inval_hint` and `fault_code` to 0. With `dat_on` 0 the mode has no effect.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Real byte address |
| req_kind | input | 2 | 00 read, 01 store, 10 fetch |
| dat_on | input | 1 | Translation enabled |
| space_mode | input | 2 | 00 primary, 01 access-register, 10 secondary, 11 home |
| lowprot_en | input | 1 | Low-address protection enable |
| priv_primary | input | 1 | Private bit of primary descriptor |
| priv_secondary | input | 1 | Private bit of secondary descriptor |
| priv_home | input | 1 | Private bit of home descriptor |
| prefix | input | ADDR_W | Prefix base (8 KiB aligned) |
| rsp_valid | output | 1 | Result valid |
| abs_addr | output | ADDR_W | Absolute address |
| prot_fault | output | 1 | Protection exception |
| fault_code | output | ADDR_W | Exception code |
| wr_inval_hint | output | 1 | Do not cache write permission for this page |
| mode_error | output | 1 | Unsupported space mode |

## Verification
The hardest case to reach is the gated guard. It needs translation on and a store to a low byte, and the result then depends only on which of three private bits the mode points at. The stimulus therefore sets the non-selected bits opposite to the selected one, so that picking the wrong descriptor would flip the outcome. A second case needs care: a store to a low page but not a low byte, at 512 and at 0x1200. It must raise the hint without a fault. Stimulus at those two bytes and at the last low byte on each side pins both window edges.

// File: rtl/lap_pkg.sv
package lap_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    SPC_PRIMARY   = 2'b00,
    SPC_AREG      = 2'b01,
    SPC_SECONDARY = 2'b10,
    SPC_HOME      = 2'b11
  } spc_mode_e;

  localparam int unsigned STORE_MARK = 'h400;
  localparam int unsigned LOWPROT_MARK = 'h80;
endpackage

// File: rtl/lap_low_window.sv
module lap_low_window #(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12,
  parameter int LOW_PAGES = 2,
  parameter int LOW_SPAN  = 512
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              is_low_o
);
  localparam int IDX_W = ADDR_W - PAGE_BITS;

  logic page_in;
  logic off_in;

  always_comb begin
    page_in  = addr_i[ADDR_W-1:PAGE_BITS] < IDX_W'(LOW_PAGES);
    off_in   = addr_i[PAGE_BITS-1:0] < PAGE_BITS'(LOW_SPAN);
    is_low_o = page_in && off_in;
  end
endmodule

// File: rtl/lap_guard.sv
module lap_guard
  import lap_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              byte_low_i,
  input  logic              page_low_i,
  input  logic [ADDR_W-1:0] page_addr_i,
  input  acc_kind_e         kind_i,
  input  logic              dat_on_i,
  input  spc_mode_e         mode_i,
  input  logic              lowprot_en_i,
  input  logic [2:0]        priv_i,
  output logic              fault_o,
  output logic              hint_o,
  output logic              mode_err_o,
  output logic [ADDR_W-1:0] code_o
);
  logic priv_sel;
  logic armed;

  always_comb begin
    priv_sel   = 1'b0;
    mode_err_o = 1'b0;
    unique case (mode_i)
      SPC_PRIMARY:   priv_sel = priv_i[0];
      SPC_SECONDARY: priv_sel = priv_i[1];
      SPC_HOME:      priv_sel = priv_i[2];
      default:       mode_err_o = dat_on_i;
    endcase
    armed   = lowprot_en_i && (!dat_on_i || !priv_sel) && !mode_err_o;
    hint_o  = armed && page_low_i;
    fault_o = armed && byte_low_i && (kind_i == ACC_WRITE);
    code_o  = fault_o ? (page_addr_i | ADDR_W'(STORE_MARK) | ADDR_W'(LOWPROT_MARK))
                      : '0;
  end

  // R6: a low byte always lies on a low page, so a fault implies the hint
  always_comb begin
    if (fault_o) a_fault_has_hint_r6: assert (hint_o);
  end
endmodule

// File: rtl/lap_prefix_map.sv
module lap_prefix_map #(
  parameter int ADDR_W     = 64,
  parameter int SWAP_BYTES = 'h2000
) (
  input  logic [ADDR_W-1:0] real_i,
  input  logic [ADDR_W-1:0] prefix_i,
  output logic [ADDR_W-1:0] abs_o
);
  localparam int SWAP_W = $clog2(SWAP_BYTES);

  logic [ADDR_W-1:0] base;
  logic              in_zero;
  logic              in_prefix;

  always_comb begin
    base      = {prefix_i[ADDR_W-1:SWAP_W], {SWAP_W{1'b0}}};
    in_zero   = real_i[ADDR_W-1:SWAP_W] == '0;
    in_prefix = real_i[ADDR_W-1:SWAP_W] == prefix_i[ADDR_W-1:SWAP_W];
    if (in_zero)        abs_o = real_i + base;
    else if (in_prefix) abs_o = real_i - base;
    else                abs_o = real_i;
  end
endmodule

// File: rtl/lap_prefix_xlate.sv
module lap_prefix_xlate
  import lap_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_BITS  = 12,
  parameter int LOW_PAGES  = 2,
  parameter int LOW_SPAN   = 512,
  parameter int SWAP_BYTES = 'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic              dat_on,
  input  logic [1:0]        space_mode,
  input  logic              lowprot_en,
  input  logic              priv_primary,
  input  logic              priv_secondary,
  input  logic              priv_home,
  input  logic [ADDR_W-1:0] prefix,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] abs_addr,
  output logic              prot_fault,
  output logic [ADDR_W-1:0] fault_code,
  output logic              wr_inval_hint,
  output logic              mode_error
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_BITS) - 1);

  logic [ADDR_W-1:0] page_addr;
  logic              byte_low;
  logic              page_low;
  logic              g_fault;
  logic              g_hint;
  logic              g_merr;
  logic [ADDR_W-1:0] g_code;
  logic [ADDR_W-1:0] mapped;

  logic              valid_d;
  logic [ADDR_W-1:0] abs_d;
  logic              fault_d;
  logic [ADDR_W-1:0] code_d;
  logic              hint_d;
  logic              merr_d;

  assign page_addr = req_addr & PAGE_MASK;

  lap_low_window #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .LOW_PAGES(LOW_PAGES), .LOW_SPAN(LOW_SPAN)
  ) u_byte_win (
    .addr_i(req_addr), .is_low_o(byte_low)
  );

  lap_low_window #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .LOW_PAGES(LOW_PAGES), .LOW_SPAN(LOW_SPAN)
  ) u_page_win (
    .addr_i(page_addr), .is_low_o(page_low)
  );

  lap_guard #(.ADDR_W(ADDR_W)) u_guard (
    .byte_low_i   (byte_low),
    .page_low_i   (page_low),
    .page_addr_i  (page_addr),
    .kind_i       (acc_kind_e'(req_kind)),
    .dat_on_i     (dat_on),
    .mode_i       (spc_mode_e'(space_mode)),
    .lowprot_en_i (lowprot_en),
    .priv_i       ({priv_home, priv_secondary, priv_primary}),
    .fault_o      (g_fault),
    .hint_o       (g_hint),
    .mode_err_o   (g_merr),
    .code_o       (g_code)
  );

  lap_prefix_map #(.ADDR_W(ADDR_W), .SWAP_BYTES(SWAP_BYTES)) u_map (
    .real_i   (req_addr),
    .prefix_i (prefix),
    .abs_o    (mapped)
  );

  // next-state
  always_comb begin
    valid_d = req_valid;
    merr_d  = g_merr;
    fault_d = g_fault;
    hint_d  = g_hint;
    code_d  = g_code;
    abs_d   = (g_fault || g_merr) ? '0 : mapped;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abs_addr      <= '0;
      prot_fault    <= 1'b0;
      fault_code    <= '0;
      wr_inval_hint <= 1'b0;
      mode_error    <= 1'b0;
    end else if (req_valid) begin
      abs_addr      <= abs_d;
      prot_fault    <= fault_d;
      fault_code    <= code_d;
      wr_inval_hint <= hint_d;
      mode_error    <= merr_d;
    end
  end

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_rsp_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_hold_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(abs_addr) && $stable(prot_fault) && $stable(wr_inval_hint)));
  p_code_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fault |-> (fault_code[11:0] == 12'h480 && abs_addr == '0));
  p_read_never_faults_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 2'b01) |=> !prot_fault);
  p_moderr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_error |-> (!prot_fault && !wr_inval_hint && abs_addr == '0));
endmodule

// File: tb/lap_prefix_xlate_test.sv
module lap_prefix_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_kind = 2'b00;
  logic          dat_on = 1'b0;
  logic [1:0]    space_mode = 2'b00;
  logic          lowprot_en = 1'b0;
  logic          priv_primary = 1'b0;
  logic          priv_secondary = 1'b0;
  logic          priv_home = 1'b0;
  logic [AW-1:0] prefix = '0;
  logic          rsp_valid;
  logic [AW-1:0] abs_addr;
  logic          prot_fault;
  logic [AW-1:0] fault_code;
  logic          wr_inval_hint;
  logic          mode_error;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lap_prefix_xlate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .dat_on(dat_on), .space_mode(space_mode),
    .lowprot_en(lowprot_en), .priv_primary(priv_primary),
    .priv_secondary(priv_secondary), .priv_home(priv_home), .prefix(prefix),
    .rsp_valid(rsp_valid), .abs_addr(abs_addr), .prot_fault(prot_fault),
    .fault_code(fault_code), .wr_inval_hint(wr_inval_hint), .mode_error(mode_error)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one request, sampled at the negedge after the capturing edge
  task automatic issue(input logic [AW-1:0] a, input logic [1:0] k);
    req_addr  = a;
    req_kind  = k;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_all(input string tag, input logic [AW-1:0] ea, input logic ef,
                            input logic [AW-1:0] ec, input logic eh, input logic em);
    chk({tag, " valid"}, AW'(rsp_valid), AW'(1));
    chk({tag, " abs"},   abs_addr, ea);
    chk({tag, " fault"}, AW'(prot_fault), AW'(ef));
    chk({tag, " code"},  fault_code, ec);
    chk({tag, " hint"},  AW'(wr_inval_hint), AW'(eh));
    chk({tag, " merr"},  AW'(mode_error), AW'(em));
  endtask

  task automatic t_reset;
    chk("R10 valid", AW'(rsp_valid), 0);
    chk("R10 abs", abs_addr, 0);
    chk("R10 fault", AW'(prot_fault), 0);
    chk("R10 code", fault_code, 0);
    chk("R10 hint", AW'(wr_inval_hint), 0);
    chk("R10 merr", AW'(mode_error), 0);
  endtask

  task automatic t_prefix_map;
    lowprot_en = 0; dat_on = 0; prefix = 'h40000;
    issue('h1234, 2'b00);  expect_all("R7 low swap", 'h41234, 0, 0, 0, 0);
    issue('h40010, 2'b01); expect_all("R8 prefix swap", 'h10, 0, 0, 0, 0);
    issue('h42000, 2'b00); expect_all("R8 above window", 'h42000, 0, 0, 0, 0);
    issue('h3FFFF, 2'b00); expect_all("R8 below window", 'h3FFFF, 0, 0, 0, 0);
    prefix = 'h41FFF;
    issue('h100, 2'b00);   expect_all("R7 prefix low bits ignored", 'h40100, 0, 0, 0, 0);
    prefix = 'h40000;
  endtask

  task automatic t_store_fault;
    lowprot_en = 1; dat_on = 0;
    issue('h1F0, 2'b01);  expect_all("R4 page0", 0, 1, 'h480, 1, 0);
    issue('h1100, 2'b01); expect_all("R4 page1", 0, 1, 'h1480, 1, 0);
    issue('h11FF, 2'b01); expect_all("R2 last low byte", 0, 1, 'h1480, 1, 0);
  endtask

  task automatic t_edges;
    lowprot_en = 1; dat_on = 0;
    issue('h200, 2'b01);  expect_all("R2 R6 byte 512", 'h40200, 0, 0, 1, 0);
    issue('h1200, 2'b01); expect_all("R2 R6 byte 4608", 'h41200, 0, 0, 1, 0);
    issue('h2000, 2'b01); expect_all("R6 page not low", 'h2000, 0, 0, 0, 0);
  endtask

  task automatic t_reads;
    lowprot_en = 1; dat_on = 0;
    issue('h10, 2'b00); expect_all("R5 read", 'h40010, 0, 0, 1, 0);
    issue('h10, 2'b10); expect_all("R5 fetch", 'h40010, 0, 0, 1, 0);
  endtask

  task automatic t_mode_gate;
    lowprot_en = 1; dat_on = 1;
    space_mode = 2'b00; priv_primary = 1; priv_secondary = 0; priv_home = 0;
    issue('h10, 2'b01); expect_all("R3 primary private", 'h40010, 0, 0, 0, 0);
    space_mode = 2'b10; priv_primary = 0; priv_secondary = 1; priv_home = 0;
    issue('h10, 2'b01); expect_all("R3 secondary private", 'h40010, 0, 0, 0, 0);
    space_mode = 2'b11; priv_primary = 1; priv_secondary = 1; priv_home = 0;
    issue('h10, 2'b01); expect_all("R3 home shared", 0, 1, 'h480, 1, 0);
    space_mode = 2'b00; priv_primary = 0; priv_secondary = 1; priv_home = 1;
    issue('h10, 2'b01); expect_all("R3 primary shared", 0, 1, 'h480, 1, 0);
    lowprot_en = 0;
    issue('h10, 2'b01); expect_all("R3 disabled", 'h40010, 0, 0, 0, 0);
    priv_primary = 0; priv_secondary = 0; priv_home = 0;
  endtask

  task automatic t_mode_error;
    lowprot_en = 1; dat_on = 1; space_mode = 2'b01;
    issue('h10, 2'b01); expect_all("R9 areg mode", 0, 0, 0, 0, 1);
    dat_on = 0;
    issue('h10, 2'b01); expect_all("R9 mode ignored dat off", 0, 1, 'h480, 1, 0);
    space_mode = 2'b00;
  endtask

  task automatic t_hold;
    lowprot_en = 0; dat_on = 0;
    issue('h40020, 2'b00); expect_all("R1 req", 'h20, 0, 0, 0, 0);
    req_addr = 'h1F0; req_kind = 2'b01; lowprot_en = 1;
    @(posedge clk); @(negedge clk);
    chk("R1 idle valid", AW'(rsp_valid), 0);
    chk("R1 idle abs hold", abs_addr, 'h20);
    chk("R1 idle fault hold", AW'(prot_fault), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_prefix_map();
    t_store_fault();
    t_edges();
    t_reads();
    t_mode_gate();
    t_mode_error();
    t_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule